// File: doc/BRIEF.md
# Timer Interrupt Flag and Mask Controller

This block gathers the interrupt events of two timer/counters into one flag register and one mask register. Both registers sit on a simple I/O bus that has an address, a write strobe, write data and combinational read data. Event pulses set flags. Software clears a flag by writing a one to its bit position. A flag is also cleared when the CPU acknowledges the vector that the block is presenting.

A source raises a request only when the global enable input, its mask bit and its flag are all high. When more than one source is requested, the one with the lowest vector address is presented. In PWM mode, the timer1 overflow flag is set by a separate direction-reversal pulse instead of the ordinary overflow pulse.

Top module: `tmr_irq_ctrl`

## Requirements
- R1: After reset, the mask register (address 0x39) and the flag register (address 0x38) both read 0x00, irq_req is low and irq_vec is 0.
- R2: A write to address 0x39 loads the mask bits at positions 7 (timer1 overflow), 6 (timer1 compare A), 3 (timer1 capture) and 1 (timer0 overflow). Bits 5, 4, 2 and 0 read zero and ignore writes.
- R3: An event pulse sets its flag at the same bit position as its mask bit (capture bit 3, compare A bit 6, timer1 overflow bit 7, timer0 overflow bit 1). The flag is visible at address 0x38 from the next cycle.
- R4: Writing a one to a flag bit at 0x38 clears that flag and writing a zero leaves it unchanged. Flag bits 5, 4, 2 and 0 always read zero.
- R5: If an event pulse and a clear of the same flag (by write or by acknowledge) occur in the same cycle, the flag is set afterwards.
- R6: irq_req is high exactly when gie is high and at least one source has both its mask bit and its flag set.
- R7: irq_vec presents the requested source with the lowest vector address: 3 for capture, 4 for compare A, 5 for timer1 overflow, 6 for timer0 overflow. It shows 0 when irq_req is low.
- R8: A one-cycle irq_ack clears only the flag of the vector presented in that cycle. An irq_ack while irq_req is low changes nothing.
- R9: While pwm_mode is high, t1_dir_flip sets the timer1 overflow flag and ev_t1_ovf is ignored. While pwm_mode is low, ev_t1_ovf sets the flag and t1_dir_flip is ignored.
- R10: Any other address reads 0x00, and writes to other addresses change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 6 | I/O register address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from bus_addr |
| ev_t1_cap | input | 1 | Timer1 input capture event pulse |
| ev_t1_cmpa | input | 1 | Timer1 compare A match pulse |
| ev_t1_ovf | input | 1 | Timer1 overflow pulse (normal mode) |
| ev_t0_ovf | input | 1 | Timer0 overflow pulse |
| t1_dir_flip | input | 1 | Timer1 direction reversal at zero (PWM mode) |
| pwm_mode | input | 1 | Selects the timer1 overflow flag source |
| gie | input | 1 | Global interrupt enable |
| irq_ack | input | 1 | CPU takes the presented vector (one-cycle pulse) |
| irq_req | output | 1 | Interrupt request |
| irq_vec | output | 8 | Presented vector address |

## Verification
The assertions are checked on every cycle. They cover these properties: an event always leaves its flag set, a write-one-to-clear without a competing event empties the written flags, and a mask write loads exactly the written bits. They also check that the grant is at most one-hot, that a request implies the global enable, and that the vector stays within the four legal addresses. Three behaviours are shown only by the bench scenarios, which compare against a behavioural model every cycle. These are the priority order when sources overlap, the acknowledge clearing only the presented flag, and the PWM-mode source swap. The scenarios also cover reserved bits and foreign addresses reading zero.

// File: rtl/tmr_irq_pkg.sv
package tmr_irq_pkg;
    localparam int NSRC = 4;
    localparam int DW   = 8;

    // source index = priority order (0 highest)
    localparam int SRC_CAP  = 0;
    localparam int SRC_CMPA = 1;
    localparam int SRC_OVF1 = 2;
    localparam int SRC_OVF0 = 3;

    typedef struct packed {
        logic [NSRC-1:0] mask;
        logic [NSRC-1:0] flag;
    } irq_state_t;

    // register bit position for each source
    function automatic int src_bit(input int idx);
        case (idx)
            SRC_CAP:  return 3;
            SRC_CMPA: return 6;
            SRC_OVF1: return 7;
            default:  return 1;
        endcase
    endfunction
endpackage

// File: rtl/tmr_irq_regs.sv
module tmr_irq_regs
    import tmr_irq_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_mask,
    input  logic            wr_flag,
    input  logic [NSRC-1:0] wdata_src,
    input  logic [NSRC-1:0] ev,
    input  logic [NSRC-1:0] ack_clr,
    output logic [NSRC-1:0] mask_o,
    output logic [NSRC-1:0] flag_o
);
    irq_state_t st_d, st_q;

    always_comb begin
        logic [NSRC-1:0] clr;
        st_d = st_q;
        clr  = ack_clr | (wr_flag ? wdata_src : '0);
        if (wr_mask)
            st_d.mask = wdata_src;
        // set wins over any clear in the same cycle
        st_d.flag = (st_q.flag & ~clr) | ev;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign mask_o = st_q.mask;
    assign flag_o = st_q.flag;

    a_r3_event_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (ev != '0) |=> ((flag_o & $past(ev)) == $past(ev)));

    a_r4_w1c_clears: assert property (@(posedge clk) disable iff (!rst_n)
        wr_flag |=> ((flag_o & $past(wdata_src) & ~$past(ev)) == '0));

    a_r2_mask_load: assert property (@(posedge clk) disable iff (!rst_n)
        wr_mask |=> (mask_o == $past(wdata_src)));

    a_r8_flags_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_flag && ev == '0 && ack_clr == '0) |=> $stable(flag_o));
endmodule

// File: rtl/tmr_irq_arb.sv
module tmr_irq_arb
    import tmr_irq_pkg::*;
#(
    parameter int VEC_W    = 8,
    parameter int VEC_BASE = 3
)(
    input  logic             gie,
    input  logic [NSRC-1:0]  mask,
    input  logic [NSRC-1:0]  flag,
    output logic [NSRC-1:0]  grant,
    output logic             req,
    output logic [VEC_W-1:0] vec
);
    logic [NSRC-1:0] pend;

    assign pend = gie ? (mask & flag) : '0;
    assign req  = |pend;

    always_comb begin
        grant = '0;
        vec   = '0;
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (pend[i]) begin
                grant    = '0;
                grant[i] = 1'b1;
                vec      = VEC_W'(VEC_BASE + i);
            end
        end
    end
endmodule

// File: rtl/tmr_irq_ctrl.sv
module tmr_irq_ctrl
    import tmr_irq_pkg::*;
#(
    parameter int          AW        = 6,
    parameter logic [AW-1:0] ADDR_FLAG = 6'h38,
    parameter logic [AW-1:0] ADDR_MASK = 6'h39,
    parameter int          VEC_W     = 8,
    parameter int          VEC_BASE  = 3
)(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [AW-1:0]    bus_addr,
    input  logic             bus_we,
    input  logic [DW-1:0]    bus_wdata,
    output logic [DW-1:0]    bus_rdata,
    input  logic             ev_t1_cap,
    input  logic             ev_t1_cmpa,
    input  logic             ev_t1_ovf,
    input  logic             ev_t0_ovf,
    input  logic             t1_dir_flip,
    input  logic             pwm_mode,
    input  logic             gie,
    input  logic             irq_ack,
    output logic             irq_req,
    output logic [VEC_W-1:0] irq_vec
);
    logic [NSRC-1:0] wsrc, ev, mask, flag, grant, ack_clr;
    logic            wr_mask, wr_flag;

    assign wr_mask = bus_we && (bus_addr == ADDR_MASK);
    assign wr_flag = bus_we && (bus_addr == ADDR_FLAG);

    for (genvar g = 0; g < NSRC; g++) begin : g_gather
        assign wsrc[g] = bus_wdata[src_bit(g)];
    end

    assign ev[SRC_CAP]  = ev_t1_cap;
    assign ev[SRC_CMPA] = ev_t1_cmpa;
    assign ev[SRC_OVF1] = pwm_mode ? t1_dir_flip : ev_t1_ovf;
    assign ev[SRC_OVF0] = ev_t0_ovf;

    assign ack_clr = irq_ack ? grant : '0;

    tmr_irq_regs i_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_mask   (wr_mask),
        .wr_flag   (wr_flag),
        .wdata_src (wsrc),
        .ev        (ev),
        .ack_clr   (ack_clr),
        .mask_o    (mask),
        .flag_o    (flag)
    );

    tmr_irq_arb #(.VEC_W(VEC_W), .VEC_BASE(VEC_BASE)) i_arb (
        .gie   (gie),
        .mask  (mask),
        .flag  (flag),
        .grant (grant),
        .req   (irq_req),
        .vec   (irq_vec)
    );

    always_comb begin
        bus_rdata = '0;
        for (int i = 0; i < NSRC; i++) begin
            if (bus_addr == ADDR_FLAG) bus_rdata[src_bit(i)] = flag[i];
            else if (bus_addr == ADDR_MASK) bus_rdata[src_bit(i)] = mask[i];
        end
    end

    a_r7_grant_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));

    a_r6_req_needs_gie: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> gie);

    a_r7_vec_range: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> (irq_vec >= VEC_W'(VEC_BASE) && irq_vec < VEC_W'(VEC_BASE + NSRC)));

    a_r8_ack_clears_grant: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ack && irq_req && (grant & ev) == '0) |=> ((flag & $past(grant)) == '0));
endmodule

// File: tb/test_tmr_irq_ctrl.sv
module test_tmr_irq_ctrl;
    logic       clk = 0, rst_n = 0;
    logic [5:0] bus_addr = 0;
    logic       bus_we = 0;
    logic [7:0] bus_wdata = 0;
    logic [7:0] bus_rdata;
    logic       ev_t1_cap = 0, ev_t1_cmpa = 0, ev_t1_ovf = 0, ev_t0_ovf = 0;
    logic       t1_dir_flip = 0, pwm_mode = 0, gie = 0, irq_ack = 0;
    logic       irq_req;
    logic [7:0] irq_vec;

    int compared = 0, mismatched = 0;
    bit done = 0;
    logic [7:0] m_mask = 0, m_flag = 0;
    int pos[4] = '{3, 6, 7, 1};

    always #4 clk = ~clk;

    tmr_irq_ctrl i_tmr_irq_ctrl (.*);

    task automatic chk(string tag, string what, int act, int exp);
        compared++;
        if (act != exp) begin
            mismatched++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // compare outputs against the model, then advance one clock
    task automatic step(string tag);
        logic [7:0] pend, set, clr, rd;
        int vec, win;
        #1;
        pend = gie ? (m_mask & m_flag) : 8'h00;
        vec = 0; win = -1;
        for (int i = 0; i < 4; i++)
            if (win < 0 && pend[pos[i]]) begin win = i; vec = 3 + i; end
        rd = (bus_addr == 6'h38) ? m_flag : (bus_addr == 6'h39) ? m_mask : 8'h00;
        chk(tag, "irq_req", irq_req, pend != 0);
        chk(tag, "irq_vec", irq_vec, vec);
        chk(tag, "rdata", bus_rdata, rd);
        set = 0;
        if (ev_t1_cap)  set[3] = 1;
        if (ev_t1_cmpa) set[6] = 1;
        if (pwm_mode ? t1_dir_flip : ev_t1_ovf) set[7] = 1;
        if (ev_t0_ovf)  set[1] = 1;
        clr = (bus_we && bus_addr == 6'h38) ? (bus_wdata & 8'hCA) : 8'h00;
        if (irq_ack && win >= 0) clr[pos[win]] = 1;
        @(posedge clk);
        m_flag = (m_flag & ~clr) | set;
        if (bus_we && bus_addr == 6'h39) m_mask = bus_wdata & 8'hCA;
        @(negedge clk);
        bus_we = 0; ev_t1_cap = 0; ev_t1_cmpa = 0; ev_t1_ovf = 0;
        ev_t0_ovf = 0; t1_dir_flip = 0; irq_ack = 0;
    endtask

    task automatic wr(string tag, logic [5:0] a, logic [7:0] d);
        bus_addr = a; bus_we = 1; bus_wdata = d; step(tag);
    endtask

    task automatic rd(string tag, logic [5:0] a);
        bus_addr = a; step(tag);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1;
        rd("R1", 6'h38); rd("R1", 6'h39);
        // R2: mask bits and reserved
        wr("R2", 6'h39, 8'hFF); rd("R2", 6'h39);
        wr("R2", 6'h39, 8'h35); rd("R2", 6'h39);
        // R3: each event sets its flag
        ev_t1_cap = 1; rd("R3", 6'h38); rd("R3", 6'h38);
        ev_t1_cmpa = 1; rd("R3", 6'h38);
        ev_t1_ovf = 1; rd("R3", 6'h38);
        ev_t0_ovf = 1; rd("R3", 6'h38); rd("R3", 6'h38);
        // R4: write zero no effect, write one clears
        wr("R4", 6'h38, 8'h00); rd("R4", 6'h38);
        wr("R4", 6'h38, 8'h35); rd("R4", 6'h38);
        wr("R4", 6'h38, 8'h48); rd("R4", 6'h38);
        // R5: set wins over clear
        ev_t1_ovf = 1; bus_addr = 6'h38; bus_we = 1; bus_wdata = 8'h82; step("R5");
        rd("R5", 6'h38);
        // R10: foreign addresses
        wr("R10", 6'h3A, 8'hFF); rd("R10", 6'h3A); rd("R10", 6'h39); rd("R10", 6'h38);
        // R6: gie/mask/flag combinations
        ev_t0_ovf = 1; rd("R6", 6'h38);
        wr("R6", 6'h39, 8'h02); rd("R6", 6'h39);
        gie = 1; rd("R6", 6'h38);
        gie = 0; rd("R6", 6'h38);
        // R7: priority with all pending
        wr("R7", 6'h39, 8'hCA); ev_t1_cap = 1; ev_t1_cmpa = 1; ev_t1_ovf = 1; rd("R7", 6'h38);
        gie = 1; rd("R7", 6'h38);
        // R8: acks walk down the priority
        irq_ack = 1; rd("R8", 6'h38);
        irq_ack = 1; rd("R8", 6'h38);
        irq_ack = 1; ev_t1_cmpa = 1; rd("R8", 6'h38);
        irq_ack = 1; rd("R8", 6'h38);
        irq_ack = 1; rd("R8", 6'h38);
        irq_ack = 1; rd("R8", 6'h38); rd("R8", 6'h38);
        // R8: ack with no request
        ev_t1_cap = 1; gie = 0; rd("R8", 6'h38);
        irq_ack = 1; rd("R8", 6'h38); rd("R8", 6'h38);
        gie = 1; irq_ack = 1; rd("R8", 6'h38); rd("R8", 6'h38);
        // R9: PWM source swap
        pwm_mode = 1; ev_t1_ovf = 1; rd("R9", 6'h38); rd("R9", 6'h38);
        t1_dir_flip = 1; rd("R9", 6'h38); rd("R9", 6'h38);
        wr("R9", 6'h38, 8'h80); pwm_mode = 0;
        t1_dir_flip = 1; rd("R9", 6'h38); rd("R9", 6'h38);
        ev_t1_ovf = 1; rd("R9", 6'h38); rd("R9", 6'h38);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            compared++; mismatched++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end
endmodule